// File: doc/BRIEF.md
# Descriptor Command Unit Sequencer

This block is the control-block sequencer of a network controller's command unit. Software places a control word in a small control block in memory and then pulses channel attention. The sequencer reads the control word and writes zero back over it. It applies the acknowledge, command-unit, receive-unit and reset fields, then writes an updated status word to the control block.

If the command unit is active, the sequencer then walks a linked list of command descriptors in memory. For each descriptor it marks the descriptor busy and fetches the command word. It hands the 3-bit opcode to an external executor and waits for that executor to report done. It then writes the completion status, follows the link and publishes the status word again. The executor is a stub that stands in for the actual transmit, address setup and configuration work. Descriptors can end the list, suspend the unit or raise the interrupt request.

All memory traffic uses one request/ready port with 16-bit data and byte addresses. The control block is laid out as follows: status word at `cb_base`, control word at `cb_base+2`, list head pointer in two halves (low half at `cb_base+4`, high half at `cb_base+6`). A descriptor at pointer `p` holds its status at `p`, its command at `p+2` and its next link at `p+4` (low half) and `p+6` (high half).

Top module: `cu_sequencer`

## Requirements
- R1: After reset `irq`, `mem_req` and `exec_req` are low. Internally the command unit is idle, the receive unit is suspended, all events are clear and the list pointer is null. The first status word after reset, with an all-zero control word, is therefore 0x0010.
- R2: On each attention pass the sequencer reads the control word at `cb_base+2` and then writes 0 there. It writes the status word `{events[3:0], 4-bit CU state, 4-bit RU state, 4'b0}` to `cb_base`. The event bits are: bit 15 command done, bit 14 frame received, bit 13 CU left active, bit 12 RU left active. CU state codes are idle 0, suspended 1 and active 2. RU state codes are idle 0 and suspended 1.
- R3: Each set bit in control bits 15:12 clears the event bit at the same position before the new events are applied.
- R4: The CU field in control bits 10:8 works as follows. Value 1 makes the CU active. Value 4 suspends the CU and sets the CU-left-active event. Any other value leaves the CU unchanged.
- R5: The RU field in control bits 6:4 works as follows. Values 1 and 2 make the RU idle. Values 3 and 4 suspend the RU and set the RU-left-active event. Any other value leaves the RU unchanged.
- R6: Control bit 7 returns events, CU, RU and the list pointer to their reset values after the other fields have been decoded.
- R7: When the CU is not suspended and the list pointer is null, the pointer is loaded from `cb_base+4` (low half) and `cb_base+6` (high half). A loaded value of zero counts as null.
- R8: For each descriptor at `p` the sequencer does these steps in order:
  - writes 0x4000 to `p`;
  - reads the command at `p+2`;
  - holds `exec_req` with `exec_op` = command[2:0] and `exec_addr` = `p` until `exec_done`;
  - writes 0xA000 to `p`;
  - reads the link at `p+4` then `p+6`;
  - writes the status word.
- R9: A link of zero or all ones becomes null, and so does any link when command bit 15 (end of list) is set. The walk continues only while the CU is active and the pointer is not null.
- R10: Command bit 14 suspends the CU after its descriptor. The pointer keeps the next link, so a later start resumes there without reloading the head.
- R11: Command bit 13 sets the command-done event and raises `irq`. `irq` then stays high until `irq_clr` is asserted.
- R12: Attention pulses that arrive while a pass is running are counted, up to 2^CNT_W-1. One further pass runs per counted pulse.
- R13: While `mem_req` is high and `mem_rdy` is low, the request, direction, address and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attn | input | 1 | Channel-attention pulse |
| cb_base | input | 32 | Byte address of the control block |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Access completes on this edge |
| exec_req | output | 1 | Descriptor execution request |
| exec_op | output | 3 | Descriptor opcode |
| exec_addr | output | 32 | Address of the descriptor being executed |
| exec_done | input | 1 | Execution finished |
| irq | output | 1 | Interrupt request level |
| irq_clr | input | 1 | Clears `irq` |

## Verification
The first request of a pass appears two edges after an idle attention pulse: one edge to count the pulse and one to leave idle. After that, each memory or execute step moves forward on the edge where ready or done is sampled, so results depend only on order and not on fixed latency. The bench therefore does not count cycles. It predicts the full ordered list of writes and execute requests for every pass, and it checks each one at the negative edge where its responder grants it. This holds whatever access latencies are in play. `irq` rises one edge after the link-high read that completes an interrupting descriptor. The bench checks `irq`, the final status word and the idle state several cycles after the predicted traffic has drained.

// File: rtl/cu_sequencer.sv
module cu_sequencer #(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        attn,
  input  logic [31:0] cb_base,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_rdy,
  output logic        exec_req,
  output logic [2:0]  exec_op,
  output logic [31:0] exec_addr,
  input  logic        exec_done,
  output logic        irq,
  input  logic        irq_clr
);

  localparam logic [31:0]      NULLP    = '1;
  localparam logic [1:0]       CU_IDLE  = 2'd0;
  localparam logic [1:0]       CU_SUSP  = 2'd1;
  localparam logic [1:0]       CU_ACT   = 2'd2;
  localparam logic [CNT_W-1:0] PEND_MAX = '1;

  typedef enum logic [3:0] {
    S_IDLE, S_RCTL, S_WCTL, S_APPLY, S_HLO, S_HHI, S_WST,
    S_DBUSY, S_DCMD, S_EXEC, S_DDONE, S_DLLO, S_DLHI
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] pend;
  logic [15:0]      ctl, cmd, lo;
  logic [31:0]      ptr;
  logic [3:0]       ev;
  logic [1:0]       cu;
  logic             ru_s;

  logic [3:0]  ev_a;
  logic [1:0]  cu_a;
  logic        ru_a;
  logic [31:0] ptr_a;

  logic        step, walk, fin, inc;
  logic [31:0] link, link_n;
  logic [15:0] stat;

  assign step   = mem_req & mem_rdy;
  assign walk   = (cu == CU_ACT) && (ptr != NULLP);
  assign fin    = (st == S_WST) && step && !walk;
  assign inc    = attn && (pend != PEND_MAX);
  assign link   = {mem_rdata, lo};
  assign link_n = (link == 32'd0) ? NULLP : link;
  assign stat   = {ev, 2'b00, cu, 3'b000, ru_s, 4'b0000};

  assign exec_req  = (st == S_EXEC);
  assign exec_op   = cmd[2:0];
  assign exec_addr = ptr;

  always_comb begin
    ev_a  = ev & ~ctl[15:12];
    cu_a  = cu;
    ru_a  = ru_s;
    ptr_a = ptr;
    case (ctl[10:8])
      3'd1: cu_a = CU_ACT;
      3'd4: begin cu_a = CU_SUSP; ev_a[1] = 1'b1; end
      default: ;
    endcase
    case (ctl[6:4])
      3'd1, 3'd2: ru_a = 1'b0;
      3'd3, 3'd4: begin ru_a = 1'b1; ev_a[0] = 1'b1; end
      default: ;
    endcase
    if (ctl[7]) begin
      ev_a  = 4'd0;
      cu_a  = CU_IDLE;
      ru_a  = 1'b1;
      ptr_a = NULLP;
    end
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = cb_base;
    mem_wdata = 16'd0;
    case (st)
      S_RCTL:  mem_addr = cb_base + 32'd2;
      S_WCTL:  begin mem_we = 1'b1; mem_addr = cb_base + 32'd2; end
      S_HLO:   mem_addr = cb_base + 32'd4;
      S_HHI:   mem_addr = cb_base + 32'd6;
      S_WST:   begin mem_we = 1'b1; mem_wdata = stat; end
      S_DBUSY: begin mem_we = 1'b1; mem_addr = ptr; mem_wdata = 16'h4000; end
      S_DCMD:  mem_addr = ptr + 32'd2;
      S_DDONE: begin mem_we = 1'b1; mem_addr = ptr; mem_wdata = 16'hA000; end
      S_DLLO:  mem_addr = ptr + 32'd4;
      S_DLHI:  mem_addr = ptr + 32'd6;
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pend <= '0;
      ctl  <= '0;
      cmd  <= '0;
      lo   <= '0;
      ptr  <= NULLP;
      ev   <= '0;
      cu   <= CU_IDLE;
      ru_s <= 1'b1;
      irq  <= 1'b0;
    end else begin
      pend <= pend + {{(CNT_W-1){1'b0}}, inc} - {{(CNT_W-1){1'b0}}, fin};
      irq  <= ((st == S_DLHI) && step && cmd[13]) | (irq & ~irq_clr);
      case (st)
        S_IDLE:  if (pend != '0) st <= S_RCTL;
        S_RCTL:  if (step) begin ctl <= mem_rdata; st <= S_WCTL; end
        S_WCTL:  if (step) st <= S_APPLY;
        S_APPLY: begin
          ev   <= ev_a;
          cu   <= cu_a;
          ru_s <= ru_a;
          ptr  <= ptr_a;
          st   <= (cu_a != CU_SUSP && ptr_a == NULLP) ? S_HLO : S_WST;
        end
        S_HLO:   if (step) begin lo <= mem_rdata; st <= S_HHI; end
        S_HHI:   if (step) begin ptr <= link_n; st <= S_WST; end
        S_WST:   if (step) st <= walk ? S_DBUSY : S_IDLE;
        S_DBUSY: if (step) st <= S_DCMD;
        S_DCMD:  if (step) begin cmd <= mem_rdata; st <= S_EXEC; end
        S_EXEC:  if (exec_done) st <= S_DDONE;
        S_DDONE: if (step) st <= S_DLLO;
        S_DLLO:  if (step) begin lo <= mem_rdata; st <= S_DLHI; end
        S_DLHI:  if (step) begin
          ptr <= cmd[15] ? NULLP : link_n;
          if (cmd[14]) cu <= CU_SUSP;
          if (cmd[13]) ev[3] <= 1'b1;
          st <= S_WST;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cu_sequencer_chk.sv
module cu_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_rdy,
  input logic        exec_req,
  input logic [2:0]  exec_op,
  input logic [31:0] exec_addr,
  input logic        exec_done,
  input logic        irq,
  input logic        irq_clr
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R13

  AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req && !exec_done |=> exec_req && $stable(exec_op) && $stable(exec_addr)); // R8

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && exec_req)); // R8

  AST_EXEC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_req) |-> $past(mem_req && !mem_we && mem_rdy)); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R11

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr)); // R11

endmodule

bind cu_sequencer cu_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
  .exec_req(exec_req), .exec_op(exec_op), .exec_addr(exec_addr),
  .exec_done(exec_done), .irq(irq), .irq_clr(irq_clr)
);

// File: tb/cu_sequencer_tb.sv
module cu_sequencer_tb;

  localparam logic [31:0] CB    = 32'h100;
  localparam logic [31:0] NULLP = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, attn, irq_clr, mem_req, mem_we, mem_rdy, exec_req, exec_done, irq;
  logic [31:0] cb_base, mem_addr, exec_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [2:0]  exec_op;

  cu_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .attn(attn), .cb_base(cb_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .exec_req(exec_req), .exec_op(exec_op), .exec_addr(exec_addr), .exec_done(exec_done),
    .irq(irq), .irq_clr(irq_clr)
  );

  logic [15:0] mem [0:255];
  logic [15:0] mm  [0:255];
  logic [47:0] wq[$];
  logic [47:0] xq[$];

  int    checks = 0, errors = 0, cyc = 0, ntx = 0, wcnt = 0, xcnt = 2;
  string cur = "R1";
  logic [1:0]  m_cu;
  logic        m_ru, m_irq;
  logic [3:0]  m_ev;
  logic [31:0] m_ptr;
  logic        pv_pend;
  logic [48:0] pv_req;

  function automatic int ix(logic [31:0] a);
    return int'(a[8:1]);
  endfunction

  function automatic logic [15:0] m_stat();
    return {m_ev, 2'b00, m_cu, 3'b000, m_ru, 4'b0000};
  endfunction

  function automatic logic [31:0] norm(logic [31:0] v);
    return (v == 32'd0) ? NULLP : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic m_wr(input logic [31:0] a, input logic [15:0] d);
    wq.push_back({a, d});
    mm[ix(a)] = d;
  endtask

  task automatic m_pass();
    logic [15:0] c, k;
    logic [31:0] nx;
    c = mm[ix(CB + 2)];
    m_wr(CB + 2, 16'd0);
    m_ev = m_ev & ~c[15:12];
    if (c[10:8] == 3'd1) m_cu = 2'd2;
    if (c[10:8] == 3'd4) begin m_cu = 2'd1; m_ev[1] = 1'b1; end
    if (c[6:4] == 3'd1 || c[6:4] == 3'd2) m_ru = 1'b0;
    if (c[6:4] == 3'd3 || c[6:4] == 3'd4) begin m_ru = 1'b1; m_ev[0] = 1'b1; end
    if (c[7]) begin m_ev = 4'd0; m_cu = 2'd0; m_ru = 1'b1; m_ptr = NULLP; end
    if (m_cu != 2'd1 && m_ptr == NULLP)
      m_ptr = norm({mm[ix(CB + 6)], mm[ix(CB + 4)]});
    m_wr(CB, m_stat());
    while (m_cu == 2'd2 && m_ptr != NULLP) begin
      m_wr(m_ptr, 16'h4000);
      k = mm[ix(m_ptr + 2)];
      xq.push_back({13'd0, k[2:0], m_ptr});
      m_wr(m_ptr, 16'hA000);
      nx = norm({mm[ix(m_ptr + 6)], mm[ix(m_ptr + 4)]});
      if (k[15]) nx = NULLP;
      if (k[14]) m_cu = 2'd1;
      if (k[13]) begin m_ev[3] = 1'b1; m_irq = 1'b1; end
      m_ptr = nx;
      m_wr(CB, m_stat());
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL %s watchdog actual=%0d expected=%0d", cur, cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst_n) begin
      mem_rdy = 1'b0; exec_done = 1'b0; pv_pend = 1'b0;
    end else begin
      if (pv_pend)
        chk(mem_req && {mem_we, mem_addr, mem_wdata} == pv_req, "R13", "request held",
            {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, pv_req[47:16]});
      mem_rdy = 1'b0;
      if (mem_req) begin
        if (wcnt == 0) begin
          mem_rdy   = 1'b1;
          mem_rdata = mem[ix(mem_addr)];
          if (mem_we) begin
            if (wq.size() == 0)
              chk(1'b0, cur, "unexpected write", {mem_addr, mem_wdata}, 48'd0);
            else begin
              logic [47:0] e;
              e = wq.pop_front();
              chk({mem_addr, mem_wdata} == e, cur, "write", {mem_addr, mem_wdata}, e);
            end
            mem[ix(mem_addr)] = mem_wdata;
          end
          ntx++;
          wcnt = ntx % 3;
        end else wcnt--;
      end
      pv_pend = mem_req && !mem_rdy;
      pv_req  = {mem_we, mem_addr, mem_wdata};
      exec_done = 1'b0;
      if (exec_req) begin
        if (xcnt == 0) begin
          exec_done = 1'b1;
          xcnt = 2;
          if (xq.size() == 0)
            chk(1'b0, cur, "unexpected exec", {13'd0, exec_op, exec_addr}, 48'd0);
          else begin
            logic [47:0] e;
            e = xq.pop_front();
            chk({13'd0, exec_op, exec_addr} == e, cur, "exec", {13'd0, exec_op, exec_addr}, e);
          end
        end else xcnt--;
      end
    end
  end

  task automatic setw(input logic [31:0] a, input logic [15:0] d);
    mem[ix(a)] = d;
    mm[ix(a)]  = d;
  endtask

  task automatic setdesc(input logic [31:0] p, input logic [15:0] c, input logic [31:0] nx);
    setw(p, 16'd0); setw(p + 2, c); setw(p + 4, nx[15:0]); setw(p + 6, nx[31:16]);
  endtask

  task automatic sethead(input logic [31:0] h);
    setw(CB + 4, h[15:0]); setw(CB + 6, h[31:16]);
  endtask

  task automatic run(input string tag, input logic [15:0] c, input int pulses);
    int n;
    cur = tag;
    setw(CB + 2, c);
    for (int i = 0; i < pulses; i++) m_pass();
    for (int i = 0; i < pulses; i++) begin
      @(negedge clk) attn = 1'b1;
      @(negedge clk) attn = 1'b0;
      repeat (3) @(negedge clk);
    end
    n = 0;
    while ((wq.size() != 0 || xq.size() != 0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, tag, "traffic drained", 48'(wq.size() + xq.size()), 48'd0);
    repeat (6) @(negedge clk);
    chk(!mem_req && !exec_req, tag, "back to idle", {46'd0, mem_req, exec_req}, 48'd0);
    chk(mem[ix(CB)] == m_stat(), tag, "final status", 48'(mem[ix(CB)]), 48'(m_stat()));
    chk(mem[ix(CB + 2)] == 16'd0, "R2", "control cleared", 48'(mem[ix(CB + 2)]), 48'd0);
    chk(irq == m_irq, tag, "irq level", 48'(irq), 48'(m_irq));
  endtask

  initial begin
    rst_n = 1'b0; attn = 1'b0; irq_clr = 1'b0; cb_base = CB;
    mem_rdy = 1'b0; exec_done = 1'b0; mem_rdata = 16'd0;
    pv_pend = 1'b0; pv_req = '0;
    for (int i = 0; i < 256; i++) begin mem[i] = 16'd0; mm[i] = 16'd0; end
    m_cu = 2'd0; m_ru = 1'b1; m_ev = 4'd0; m_ptr = NULLP; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!irq && !mem_req && !exec_req, "R1", "reset outputs",
        {45'd0, irq, mem_req, exec_req}, 48'd0);

    // R1 R2 R7: idle pass, zero head treated as null, status 0x0010
    sethead(32'd0);
    run("R1", 16'h0000, 1);
    chk(mem[ix(CB)] == 16'h0010, "R1", "reset status word", 48'(mem[ix(CB)]), 48'h0010);

    // R4 R5 R8 R11: start both units, three descriptors, middle one interrupts
    setdesc(32'h20, 16'h0004, 32'h40);
    setdesc(32'h40, 16'h2001, 32'h60);
    setdesc(32'h60, 16'h8000, 32'h80);
    sethead(32'h20);
    run("R8", 16'h0110, 1);
    chk(mem[ix(32'h40)] == 16'hA000, "R8", "descriptor complete", 48'(mem[ix(32'h40)]), 48'hA000);
    chk(irq == 1'b1, "R11", "irq raised", 48'(irq), 48'd1);

    cur = "R11";
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    m_irq = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R11", "irq cleared", 48'(irq), 48'd0);

    // R3: acknowledge command-done, new head with one end-of-list entry
    setdesc(32'h80, 16'h8003, 32'd0);
    sethead(32'h80);
    run("R3", 16'h8000, 1);
    chk(mem[ix(CB)] == 16'h0200, "R3", "event acked", 48'(mem[ix(CB)]), 48'h0200);

    // R10: suspend after first descriptor, pointer keeps next link
    setdesc(32'h20, 16'h4002, 32'h40);
    setdesc(32'h40, 16'h0000, 32'd0);
    sethead(32'h20);
    run("R10", 16'h0000, 1);

    // R4: abort while suspended, no head reload
    run("R4", 16'h0400, 1);
    chk(mem[ix(CB)] == 16'h2100, "R4", "abort status", 48'(mem[ix(CB)]), 48'h2100);

    // R9 R10: ack + start resumes at saved link, zero link ends walk
    run("R9", 16'h2100, 1);

    // R5: receive unit suspend
    setdesc(32'h20, 16'h8000, 32'd0);
    run("R5", 16'h0030, 1);

    // R6: reset bit overrides start
    run("R6", 16'h0180, 1);
    chk(mem[ix(CB)] == 16'h0010, "R6", "reset via control", 48'(mem[ix(CB)]), 48'h0010);

    // R12: three pulses, second and third while busy
    setdesc(32'h20, 16'h8006, 32'd0);
    run("R12", 16'h0100, 3);

    // R9: all-ones link ends the walk
    setdesc(32'h20, 16'h0005, NULLP);
    run("R9", 16'h0000, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule